// File: doc/BRIEF.md
# Function-Coded 32-bit ALU with Condition Flags

This block is the arithmetic and logic stage of a datapath. Two operand registers capture the A and B words when a load enable is high. From the held operands, a 6-bit function code and a carry input, the block produces a result word and four flags: negative, zero, carry and overflow. The result and flags are combinational from the held operands, the function code and the carry input.

Inside the block, an adder and a bitwise logic unit work side by side on the same held operands. The function code is decoded into a control word. That word sets an XOR inversion on each adder operand, picks the logic operation, and drives a result multiplexer that chooses the logic or the adder output. The adder is a carry-select structure. Every segment forms a sum for an incoming carry of zero and for an incoming carry of one, and the real carry picks between them. Codes outside the defined set give a zero result with every flag clear, so the output is always fully defined.

Top module: `opfn_alu`

## Requirements
- R1: A synchronous active-high reset clears both operand registers, so that after reset code 000000 (pass A) gives result 0 with the zero flag set.
- R2: An operand register takes its input word at a rising clock edge only when the load enable is high. With the enable low, both held operands keep their values, and the result for an unchanged code and carry stays the same.
- R3: The bitwise codes give these results from the held operands: 000100 gives A AND B, 001000 gives A AND NOT B, 001001 gives A XOR B, and 000001 gives A OR B.
- R4: The transfer codes give these results: 000000 gives A, 000101 gives B, 001010 gives NOT B, and 001100 gives the constant zero.
- R5: The arithmetic codes give these results modulo 2^32: 010110 gives A + B + cin, 011001 gives A + NOT B + cin, and 110110 gives NOT A + B + cin.
- R6: For an arithmetic code, the carry flag equals bit 32 of the full 33-bit sum of the two adder inputs (after inversion) and the carry input.
- R7: For an arithmetic code, the overflow flag is 1 exactly when the two adder inputs (after inversion) have the same bit 31 and bit 31 of the sum differs from it.
- R8: For every defined code, the negative flag equals bit 31 of the result, and the zero flag is 1 exactly when all 32 result bits are 0.
- R9: For every bitwise and transfer code (R3, R4), the carry and overflow flags are 0.
- R10: Every function code outside the eleven codes of R3 to R5 gives result 0 with all four flags 0, the zero flag included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the operand registers |
| ld_en | input | 1 | Load enable for both operand registers |
| opa_in | input | 32 | Operand A word to be captured |
| opb_in | input | 32 | Operand B word to be captured |
| fsel | input | 6 | Function code |
| cin | input | 1 | Carry input to the adder |
| res | output | 32 | Result word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Each of the eleven defined codes is applied to fixed operand pairs with interleaved bit patterns. A wrong logic operation or a wrong inversion changes different bits for each pair, so these pairs tell the codes apart. The adder is driven with values that carry across segment boundaries, with all-ones plus one, with signed-limit operands and with equal-operand subtraction. These cases separate carry-select errors, carry-flag errors and overflow-rule errors. A sweep over all 64 codes confirms that the undefined codes give zero. Load-enable-low cycles with changing inputs show whether the held operands move. Random operands, codes and carries then cover the rest.

// File: rtl/alu_fn_pkg.sv
package alu_fn_pkg;

  typedef enum logic [2:0] {
    LG_PASS_A = 3'd0,
    LG_AND    = 3'd1,
    LG_ANDN   = 3'd2,
    LG_XOR    = 3'd3,
    LG_OR     = 3'd4,
    LG_PASS_B = 3'd5,
    LG_NOT_B  = 3'd6,
    LG_ZERO   = 3'd7
  } lg_op_e;

  typedef struct packed {
    logic   legal;
    logic   arith;
    logic   inv_a;
    logic   inv_b;
    lg_op_e lop;
  } fn_ctrl_t;

  localparam int FSEL_W = 6;

  localparam logic [FSEL_W-1:0] FN_PASS_A = 6'b000000;
  localparam logic [FSEL_W-1:0] FN_OR     = 6'b000001;
  localparam logic [FSEL_W-1:0] FN_AND    = 6'b000100;
  localparam logic [FSEL_W-1:0] FN_PASS_B = 6'b000101;
  localparam logic [FSEL_W-1:0] FN_ANDN   = 6'b001000;
  localparam logic [FSEL_W-1:0] FN_XOR    = 6'b001001;
  localparam logic [FSEL_W-1:0] FN_NOT_B  = 6'b001010;
  localparam logic [FSEL_W-1:0] FN_ZERO   = 6'b001100;
  localparam logic [FSEL_W-1:0] FN_ADD    = 6'b010110;
  localparam logic [FSEL_W-1:0] FN_SUB    = 6'b011001;
  localparam logic [FSEL_W-1:0] FN_RSB    = 6'b110110;

endpackage

// File: rtl/alu_opnd_reg.sv
module alu_opnd_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (ld) begin
      q <= d;
    end
  end

endmodule

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
  import alu_fn_pkg::*;
(
  input  logic [FSEL_W-1:0] fsel,
  output fn_ctrl_t          ctrl
);

  always_comb begin
    ctrl       = '0;
    ctrl.lop   = LG_ZERO;
    ctrl.legal = 1'b1;
    unique case (fsel)
      FN_PASS_A: ctrl.lop = LG_PASS_A;
      FN_OR:     ctrl.lop = LG_OR;
      FN_AND:    ctrl.lop = LG_AND;
      FN_PASS_B: ctrl.lop = LG_PASS_B;
      FN_ANDN:   ctrl.lop = LG_ANDN;
      FN_XOR:    ctrl.lop = LG_XOR;
      FN_NOT_B:  ctrl.lop = LG_NOT_B;
      FN_ZERO:   ctrl.lop = LG_ZERO;
      FN_ADD: begin
        ctrl.arith = 1'b1;
      end
      FN_SUB: begin
        ctrl.arith = 1'b1;
        ctrl.inv_b = 1'b1;
      end
      FN_RSB: begin
        ctrl.arith = 1'b1;
        ctrl.inv_a = 1'b1;
      end
      default: ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_fn_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  lg_op_e       lop,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (lop)
      LG_PASS_A: y = a;
      LG_AND:    y = a & b;
      LG_ANDN:   y = a & ~b;
      LG_XOR:    y = a ^ b;
      LG_OR:     y = a | b;
      LG_PASS_B: y = b;
      LG_NOT_B:  y = ~b;
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/alu_csel_adder.sv
module alu_csel_adder #(
  parameter int W   = 32,
  parameter int SEG = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam int NSEG = W / SEG;

  logic [W-1:0]   xa, xb;
  logic [SEG-1:0] p0 [NSEG];
  logic [SEG-1:0] p1 [NSEG];
  logic [NSEG-1:0] k0, k1;

  assign xa = a ^ {W{inv_a}};
  assign xb = b ^ {W{inv_b}};

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG:0] s0, s1;
    assign s0 = {1'b0, xa[g*SEG +: SEG]} + {1'b0, xb[g*SEG +: SEG]};
    assign s1 = {1'b0, xa[g*SEG +: SEG]} + {1'b0, xb[g*SEG +: SEG]}
              + {{SEG{1'b0}}, 1'b1};
    assign p0[g] = s0[SEG-1:0];
    assign p1[g] = s1[SEG-1:0];
    assign k0[g] = s0[SEG];
    assign k1[g] = s1[SEG];
  end

  always_comb begin
    logic c;
    c   = cin;
    sum = '0;
    for (int i = 0; i < NSEG; i++) begin
      sum[i*SEG +: SEG] = c ? p1[i] : p0[i];
      c                 = c ? k1[i] : k0[i];
    end
    cout = c;
  end

  assign ovf = (xa[W-1] == xb[W-1]) && (sum[W-1] != xa[W-1]);

endmodule

// File: rtl/opfn_alu.sv
module opfn_alu
  import alu_fn_pkg::*;
#(
  parameter int W   = 32,
  parameter int SEG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [W-1:0]      opa_in,
  input  logic [W-1:0]      opb_in,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              cin,
  output logic [W-1:0]      res,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);

  logic [W-1:0] a_q, b_q;
  fn_ctrl_t     ctrl;
  logic [W-1:0] lg_y, ad_y;
  logic         ad_c, ad_v;

  alu_opnd_reg #(.W(W)) u_areg (
    .clk(clk), .rst(rst), .ld(ld_en), .d(opa_in), .q(a_q)
  );

  alu_opnd_reg #(.W(W)) u_breg (
    .clk(clk), .rst(rst), .ld(ld_en), .d(opb_in), .q(b_q)
  );

  alu_fn_decode u_dec (
    .fsel(fsel), .ctrl(ctrl)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a(a_q), .b(b_q), .lop(ctrl.lop), .y(lg_y)
  );

  alu_csel_adder #(.W(W), .SEG(SEG)) u_add (
    .a(a_q), .b(b_q), .inv_a(ctrl.inv_a), .inv_b(ctrl.inv_b), .cin(cin),
    .sum(ad_y), .cout(ad_c), .ovf(ad_v)
  );

  always_comb begin
    res    = '0;
    flag_c = 1'b0;
    flag_v = 1'b0;
    if (ctrl.legal) begin
      if (ctrl.arith) begin
        res    = ad_y;
        flag_c = ad_c;
        flag_v = ad_v;
      end else begin
        res = lg_y;
      end
    end
    flag_n = ctrl.legal & res[W-1];
    flag_z = ctrl.legal & ~|res;
  end

endmodule

// File: rtl/opfn_alu_chk.sv
module opfn_alu_chk
  import alu_fn_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_en,
  input logic [FSEL_W-1:0] fsel,
  input logic              cin,
  input logic [W-1:0]      a_q,
  input logic [W-1:0]      b_q,
  input logic [W-1:0]      res,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v
);

  logic is_arith, is_def;
  assign is_arith = (fsel == FN_ADD) || (fsel == FN_SUB) || (fsel == FN_RSB);
  assign is_def   = is_arith || (fsel == FN_PASS_A) || (fsel == FN_OR) ||
                    (fsel == FN_AND) || (fsel == FN_PASS_B) || (fsel == FN_ANDN) ||
                    (fsel == FN_XOR) || (fsel == FN_NOT_B) || (fsel == FN_ZERO);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (a_q == '0) && (b_q == '0));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_en ##1 ($stable(fsel) && $stable(cin))) |-> $stable(res));

  // R6
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (fsel == FN_ADD) |-> ({flag_c, res} == ({1'b0, a_q} + {1'b0, b_q} + {{W{1'b0}}, cin})));

  // R9
  logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (is_def && !is_arith) |-> (!flag_c && !flag_v));

  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !is_def |-> (res == '0) && !flag_n && !flag_z && !flag_c && !flag_v);

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    is_def |-> (flag_z == (res == '0)));

endmodule

bind opfn_alu opfn_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ld_en(ld_en), .fsel(fsel), .cin(cin),
  .a_q(a_q), .b_q(b_q), .res(res),
  .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/opfn_alu_bench.sv
module opfn_alu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [31:0] opa_in = '0, opb_in = '0;
  logic [5:0]  fsel = '0;
  logic        cin = 1'b0;
  logic [31:0] res;
  logic        flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] ma = '0, mb = '0;

  always #5 clk = ~clk;

  opfn_alu u_opfn_alu (
    .clk(clk), .rst(rst), .ld_en(ld_en), .opa_in(opa_in), .opb_in(opb_in),
    .fsel(fsel), .cin(cin), .res(res),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  always @(posedge clk) begin
    if (rst) begin
      ma <= '0;
      mb <= '0;
    end else if (ld_en) begin
      ma <= opa_in;
      mb <= opb_in;
    end
  end

  function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [5:0] f, input logic ci);
    logic [31:0] r;
    logic [32:0] s;
    logic [31:0] x, y;
    logic c, v, ok;
    r = 0; c = 0; v = 0; ok = 1;
    case (f)
      6'b000000: r = a;
      6'b000001: r = a | b;
      6'b000100: r = a & b;
      6'b000101: r = b;
      6'b001000: r = a & ~b;
      6'b001001: r = a ^ b;
      6'b001010: r = ~b;
      6'b001100: r = 0;
      6'b010110, 6'b011001, 6'b110110: begin
        x = (f == 6'b110110) ? ~a : a;
        y = (f == 6'b011001) ? ~b : b;
        s = 33'(x) + 33'(y) + 33'(ci);
        r = s[31:0];
        c = s[32];
        v = (x[31] == y[31]) && (r[31] != x[31]);
      end
      default: ok = 0;
    endcase
    return {ok & r[31], ok & (r == 0), c, v, r};
  endfunction

  function automatic string tag_of(input logic [5:0] f);
    case (f)
      6'b000001, 6'b000100, 6'b001000, 6'b001001: return "R3";
      6'b000000, 6'b000101, 6'b001010, 6'b001100: return "R4";
      6'b010110, 6'b011001, 6'b110110: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check_now(input string tag);
    logic [35:0] e;
    e = model(ma, mb, fsel, cin);
    checks++;
    if ({flag_n, flag_z, flag_c, flag_v, res} !== e) begin
      errors++;
      $display("FAIL %s f=%b nzcv/res act=%b/%h exp=%b/%h", tag, fsel,
               {flag_n, flag_z, flag_c, flag_v}, res, e[35:32], e[31:0]);
    end
  endtask

  // Load operands, then evaluate code f with carry ci in the following cycle.
  task automatic run(input logic [31:0] a, input logic [31:0] b,
                     input logic [5:0] f, input logic ci, input string tag);
    @(negedge clk);
    ld_en = 1; opa_in = a; opb_in = b;
    @(negedge clk);
    ld_en = 0; fsel = f; cin = ci;
    #1 check_now(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    fsel = 6'b000000;
    #1 check_now("R1");
    checks++;
    if (!(res == 0 && flag_z == 1)) begin
      errors++;
      $display("FAIL R1 reset res=%h z=%b exp=00000000 z=1", res, flag_z);
    end
    @(negedge clk); rst = 0;

    // R3 and R4 on distinct patterns
    for (int p = 0; p < 3; p++) begin
      logic [31:0] pa, pb;
      pa = (p == 0) ? 32'h0F0F_3C3C : (p == 1) ? 32'hFFFF_0000 : 32'h8000_0001;
      pb = (p == 0) ? 32'h00FF_5A5A : (p == 1) ? 32'h0F0F_F0F0 : 32'h8000_0001;
      foreach (run_codes[k]) run(pa, pb, run_codes[k], 1'b1, tag_of(run_codes[k]));
    end

    // R5 R6 R7 boundary cases
    run(32'hFFFF_FFFF, 32'h0000_0001, 6'b010110, 0, "R6");
    run(32'h7FFF_FFFF, 32'h0000_0001, 6'b010110, 0, "R7");
    run(32'h8000_0000, 32'h8000_0000, 6'b010110, 0, "R7");
    run(32'h0000_00FF, 32'h0000_0001, 6'b010110, 0, "R5");
    run(32'h00FF_FFFF, 32'h0000_0000, 6'b010110, 1, "R5");
    run(32'h1234_5678, 32'h1234_5678, 6'b011001, 1, "R8");
    run(32'h0000_0005, 32'h0000_0009, 6'b011001, 1, "R6");
    run(32'h8000_0000, 32'h0000_0001, 6'b011001, 1, "R7");
    run(32'h0000_0003, 32'h0000_0010, 6'b110110, 1, "R5");
    run(32'h0000_0010, 32'h0000_0003, 6'b110110, 1, "R8");

    // R9: logic codes with operands that would carry
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'b000001, 1, "R9");
    run(32'h7FFF_FFFF, 32'h7FFF_FFFF, 6'b001001, 1, "R9");

    // R10: sweep every code
    for (int f = 0; f < 64; f++) run(32'hDEAD_BEEF, 32'h0000_0000, 6'(f), 1, tag_of(6'(f)));

    // R2: hold with load enable low
    run(32'hA5A5_0001, 32'h0101_0101, 6'b010110, 0, "R2");
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      ld_en = 0; opa_in = 32'(h * 32'h1357_9BDF); opb_in = ~opa_in;
      #1 check_now("R2");
      checks++;
      if (res !== 32'hA6A6_0102) begin
        errors++;
        $display("FAIL R2 hold res=%h exp=a6a60102", res);
      end
    end

    // random coverage, compared every clock
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      ld_en = $urandom_range(0, 1);
      opa_in = $urandom; opb_in = $urandom;
      fsel = (i % 3 == 0) ? 6'($urandom) : run_codes[$urandom_range(0, 10)];
      cin = $urandom_range(0, 1);
      #1 check_now(tag_of(fsel));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [5:0] run_codes [11] = '{6'b000000, 6'b000001, 6'b000100, 6'b000101,
                                 6'b001000, 6'b001001, 6'b001010, 6'b001100,
                                 6'b010110, 6'b011001, 6'b110110};

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule